// File: doc/BRIEF.md
# USB IN Endpoint Buffer Controller

This block sequences one IN endpoint of a USB device. It does not hold the packet bytes. It tracks how many packets are waiting in a one-slot or two-slot packet store, and it tells the packet store which slot the next IN reply should read from. It also tells firmware which slot the next packet should be written to. When the serial engine reports an IN token, the block chooses the reply: a data packet carrying the current toggle, NAK or STALL. It then waits for the host's ACK or for a timeout. An ACK advances the buffer, flips the toggle and raises a one-cycle interrupt request. A timeout leaves everything in place, so the next token sends the same packet again.

Two transfer styles are selectable. In the normal interrupt style, the block answers NAK when nothing is loaded. In the rate-feedback style, it never answers NAK. An acknowledged packet stays readable and is sent again until firmware supplies a newer one. The parameter `DOUBLE_BUF` selects one or two slots, and it also selects the meaning of the 2-bit status code that firmware reads.

All bus-side and firmware-side controls are single-cycle strobes or plain levels. The reply is a one-cycle `rsp_valid` strobe with no back-pressure, because the serial engine must answer inside a fixed bus turnaround and always accepts it.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: An IN token seen while `fw_send_stall` is high gets reply STALL (code 4), whatever the mode and the buffer contents.
- R2: In normal mode, a token without stall gets NAK (code 3) when no packet is loaded. Otherwise it gets DATA0 (code 1) or DATA1 (code 2), following the current toggle.
- R3: In rate-feedback mode, a token without stall never gets NAK. It always gets the data code of the current toggle.
- R4: An ACK that follows a data reply flips the toggle and pulses `ep_irq` for exactly one cycle, in the cycle after the ACK. It also removes one loaded packet, if there is one.
- R5: When no packet is loaded, a data reply reads `rsp_slot` from the last slot that was acknowledged. This keeps a rate-feedback packet available after its ACK.
- R6: A timeout with auto-flush off changes neither the toggle nor the status. The next token resends the same slot with the same data code.
- R7: With one slot, `buf_sts` is 00 when empty and 11 when one packet is loaded. It is never 01 or 10.
- R8: With two slots, `buf_sts` is 00 for none, 10 for one and 11 for two loaded packets. It is never 01.
- R9: `buf_sts` changes only on a packet-ready strobe, an acknowledged transfer, a flush, or a timeout with auto-flush on.
- R10: A packet-ready strobe is ignored when the status shows no room. `wr_slot` advances, with wrap, only on an accepted strobe.
- R11: `fw_flush`, or a timeout while `fw_auto_flush_en` is high, empties the buffer to status 00.
- R12: Toggle-init with status 00 sets the toggle to DATA0 and both slot indices to 0. With any other status, it has no effect.
- R13: `rsp_valid` is high for exactly the one cycle after each token strobe. A cycle without a token produces no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_pkt_ready | input | 1 | Strobe: firmware has written a packet into `wr_slot` |
| fw_flush | input | 1 | Strobe: discard all loaded packets |
| fw_auto_flush_en | input | 1 | Level: a timeout discards the buffer instead of keeping it for a retry |
| fw_toggle_init | input | 1 | Strobe: reset the toggle and slot indices (only when empty) |
| fw_send_stall | input | 1 | Level: answer every token with STALL |
| fw_rate_fb | input | 1 | Level: 1 selects rate-feedback mode, 0 selects normal interrupt mode |
| bus_in_token | input | 1 | Strobe: an IN token for this endpoint arrived |
| bus_ack | input | 1 | Strobe: the host acknowledged the last data packet |
| bus_timeout | input | 1 | Strobe: no handshake arrived for the last data packet |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_code` and `rsp_slot` hold a reply |
| rsp_code | output | 3 | 0 none, 1 DATA0, 2 DATA1, 3 NAK, 4 STALL |
| rsp_slot | output | 1 | Slot the serial engine reads for a data reply |
| wr_slot | output | 1 | Slot firmware fills next |
| buf_sts | output | 2 | Buffer status code (see R7, R8) |
| ep_irq | output | 1 | One-cycle endpoint IN interrupt request |

## Verification
The assertions assume that only one strobe among token, ACK, timeout, packet-ready, flush and toggle-init arrives in a given cycle. They also assume that an ACK or a timeout is reported only for a packet that was actually sent. The quiet-status and retry properties exclude the other strobes in their antecedents, so they do not depend on this ordering. The bench drives exactly one strobe per operation, with an idle cycle after each. It sends ACK and timeout strobes freely, including when no data packet is outstanding, because the block must ignore those. Mode and auto-flush levels change only between operations.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_DATA0 = 3'd1,
    RSP_DATA1 = 3'd2,
    RSP_NAK   = 3'd3,
    RSP_STALL = 3'd4
  } rsp_e;

  localparam int CNT_W = 2;

  // Status code from packet count; the double layout marks one packet as 10.
  function automatic logic [1:0] sts_encode(input logic dbl, input logic [CNT_W-1:0] cnt);
    logic [1:0] s;
    case (cnt)
      2'd0:    s = 2'b00;
      2'd1:    s = dbl ? 2'b10 : 2'b11;
      default: s = 2'b11;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/usb_in_ep_slots.sv
module usb_in_ep_slots
  import usb_in_ep_pkg::*;
#(
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic             consume,
  input  logic             flush_all,
  input  logic             ptr_clear,
  output logic [CNT_W-1:0] cnt,
  output logic             rd_slot,
  output logic             wr_slot,
  output logic             last_slot
);

  localparam int NSLOT = DOUBLE_BUF ? 2 : 1;
  localparam logic [CNT_W-1:0] CAP = CNT_W'(NSLOT);

  logic rd_adv, wr_adv, load_ok, con_ok;

  generate
    if (NSLOT == 1) begin : g_one
      assign rd_adv = 1'b0;
      assign wr_adv = 1'b0;
    end else begin : g_two
      assign rd_adv = ~rd_slot;
      assign wr_adv = ~wr_slot;
    end
  endgenerate

  assign load_ok = load_req && (cnt != CAP);
  assign con_ok  = consume && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      rd_slot   <= 1'b0;
      wr_slot   <= 1'b0;
      last_slot <= 1'b0;
    end else if (flush_all) begin
      cnt     <= '0;
      rd_slot <= wr_slot;
    end else if (ptr_clear) begin
      rd_slot   <= 1'b0;
      wr_slot   <= 1'b0;
      last_slot <= 1'b0;
    end else begin
      cnt <= cnt + CNT_W'(load_ok) - CNT_W'(con_ok);
      if (load_ok) wr_slot <= wr_adv;
      if (con_ok) begin
        rd_slot   <= rd_adv;
        last_slot <= rd_slot;
      end
    end
  end

endmodule

// File: rtl/usb_in_ep_toggle.sv
module usb_in_ep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  input  logic clear,
  output logic tog
);

  always_ff @(posedge clk) begin
    if (!rst_n)     tog <= 1'b0;
    else if (clear) tog <= 1'b0;
    else if (flip)  tog <= ~tog;
  end

endmodule

// File: rtl/usb_in_ep_reply.sv
module usb_in_ep_reply
  import usb_in_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok,
  input  logic       stall,
  input  logic       rate_fb,
  input  logic       have_pkt,
  input  logic       tog,
  input  logic       rd_slot,
  input  logic       last_slot,
  input  logic       end_xfer,
  output logic       rsp_valid,
  output logic [2:0] rsp_code,
  output logic       rsp_slot,
  output logic       awaiting
);

  rsp_e pick;
  logic send_data;

  always_comb begin
    send_data = 1'b0;
    if (stall) begin
      pick = RSP_STALL;
    end else if (rate_fb || have_pkt) begin
      pick      = tog ? RSP_DATA1 : RSP_DATA0;
      send_data = 1'b1;
    end else begin
      pick = RSP_NAK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_NONE;
      rsp_slot  <= 1'b0;
      awaiting  <= 1'b0;
    end else begin
      rsp_valid <= tok;
      rsp_code  <= tok ? pick : RSP_NONE;
      if (tok) begin
        rsp_slot <= have_pkt ? rd_slot : last_slot;
        awaiting <= send_data;
      end else if (end_xfer) begin
        awaiting <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import usb_in_ep_pkg::*;
#(
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fw_pkt_ready,
  input  logic       fw_flush,
  input  logic       fw_auto_flush_en,
  input  logic       fw_toggle_init,
  input  logic       fw_send_stall,
  input  logic       fw_rate_fb,
  input  logic       bus_in_token,
  input  logic       bus_ack,
  input  logic       bus_timeout,
  output logic       rsp_valid,
  output logic [2:0] rsp_code,
  output logic       rsp_slot,
  output logic       wr_slot,
  output logic [1:0] buf_sts,
  output logic       ep_irq
);

  logic [CNT_W-1:0] cnt;
  logic rd_slot, last_slot, tog, awaiting;
  logic consume, flush_all, ptr_clear, end_xfer;

  assign consume   = bus_ack && awaiting;
  assign flush_all = fw_flush || (bus_timeout && awaiting && fw_auto_flush_en);
  assign ptr_clear = fw_toggle_init && (cnt == '0);
  assign end_xfer  = bus_ack || bus_timeout || flush_all || ptr_clear;

  usb_in_ep_slots #(.DOUBLE_BUF(DOUBLE_BUF)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (fw_pkt_ready),
    .consume   (consume),
    .flush_all (flush_all),
    .ptr_clear (ptr_clear),
    .cnt       (cnt),
    .rd_slot   (rd_slot),
    .wr_slot   (wr_slot),
    .last_slot (last_slot)
  );

  usb_in_ep_toggle u_toggle (
    .clk   (clk),
    .rst_n (rst_n),
    .flip  (consume),
    .clear (ptr_clear),
    .tog   (tog)
  );

  usb_in_ep_reply u_reply (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok       (bus_in_token),
    .stall     (fw_send_stall),
    .rate_fb   (fw_rate_fb),
    .have_pkt  (cnt != '0),
    .tog       (tog),
    .rd_slot   (rd_slot),
    .last_slot (last_slot),
    .end_xfer  (end_xfer),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsp_slot  (rsp_slot),
    .awaiting  (awaiting)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ep_irq <= 1'b0;
    else        ep_irq <= consume;
  end

  assign buf_sts = sts_encode(DOUBLE_BUF, cnt);

endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
module usb_in_ep_ctrl_chk
  import usb_in_ep_pkg::*;
#(
  parameter bit DOUBLE_BUF = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_ready,
  input logic       flush,
  input logic       af,
  input logic       tinit,
  input logic       stall,
  input logic       rfb,
  input logic       tok,
  input logic       ack,
  input logic       tmo,
  input logic       rsp_valid,
  input logic [2:0] rsp_code,
  input logic [1:0] buf_sts,
  input logic       ep_irq,
  input logic       tog,
  input logic       awaiting
);

  AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    tok && stall |=> rsp_valid && rsp_code == RSP_STALL); // R1

  AST_NAK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tok && !stall && !rfb && buf_sts == 2'b00 |=> rsp_code == RSP_NAK); // R2

  AST_RFB_NO_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    tok && !stall && rfb |=> rsp_code != RSP_NAK); // R3

  AST_ACK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    ack && awaiting && !tinit |=> ep_irq && tog != $past(tog)); // R4

  AST_RETRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    tmo && !af && !ack && !pkt_ready && !flush && !tinit |=> $stable(tog) && $stable(buf_sts)); // R6

  generate
    if (!DOUBLE_BUF) begin : g_sb
      AST_STS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_sts == 2'b00 || buf_sts == 2'b11); // R7
    end else begin : g_db
      AST_STS_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_sts != 2'b01); // R8
    end
  endgenerate

  AST_STS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_ready && !ack && !flush && !tmo |=> $stable(buf_sts)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_sts == 2'b11 && !ack && !flush && !tmo |=> buf_sts == 2'b11); // R10

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> buf_sts == 2'b00); // R11

  AST_TINIT_DATA0: assert property (@(posedge clk) disable iff (!rst_n)
    tinit && buf_sts == 2'b00 |=> !tog); // R12

  AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !tok |=> !rsp_valid); // R13

  AST_IRQ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |=> !ep_irq || $past(ack)); // R4

endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk #(.DOUBLE_BUF(DOUBLE_BUF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_ready (fw_pkt_ready),
  .flush     (fw_flush),
  .af        (fw_auto_flush_en),
  .tinit     (fw_toggle_init),
  .stall     (fw_send_stall),
  .rfb       (fw_rate_fb),
  .tok       (bus_in_token),
  .ack       (bus_ack),
  .tmo       (bus_timeout),
  .rsp_valid (rsp_valid),
  .rsp_code  (rsp_code),
  .buf_sts   (buf_sts),
  .ep_irq    (ep_irq),
  .tog       (tog),
  .awaiting  (awaiting)
);

// File: tb/test_usb_in_ep_ctrl.sv
`timescale 1ns/1ps
module test_usb_in_ep_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_ready = 0, flush = 0, af = 0, tinit = 0, stall = 0, rfb = 0;
  logic tok = 0, ack = 0, tmo = 0;

  logic       rv [2];
  logic [2:0] rc [2];
  logic       rs [2];
  logic       ws [2];
  logic [1:0] st [2];
  logic       irq[2];

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_in_ep_ctrl #(.DOUBLE_BUF(1'b1)) i_usb_in_ep_ctrl (
    .clk(clk), .rst_n(rst_n), .fw_pkt_ready(pkt_ready), .fw_flush(flush),
    .fw_auto_flush_en(af), .fw_toggle_init(tinit), .fw_send_stall(stall),
    .fw_rate_fb(rfb), .bus_in_token(tok), .bus_ack(ack), .bus_timeout(tmo),
    .rsp_valid(rv[1]), .rsp_code(rc[1]), .rsp_slot(rs[1]), .wr_slot(ws[1]),
    .buf_sts(st[1]), .ep_irq(irq[1]));

  usb_in_ep_ctrl #(.DOUBLE_BUF(1'b0)) i_usb_in_ep_ctrl_single (
    .clk(clk), .rst_n(rst_n), .fw_pkt_ready(pkt_ready), .fw_flush(flush),
    .fw_auto_flush_en(af), .fw_toggle_init(tinit), .fw_send_stall(stall),
    .fw_rate_fb(rfb), .bus_in_token(tok), .bus_ack(ack), .bus_timeout(tmo),
    .rsp_valid(rv[0]), .rsp_code(rc[0]), .rsp_slot(rs[0]), .wr_slot(ws[0]),
    .buf_sts(st[0]), .ep_irq(irq[0]));

  // Reference state, index 0 = one slot, 1 = two slots
  int m_cnt[2], m_tog[2], m_rd[2], m_wr[2], m_last[2], m_aw[2];

  function automatic int enc(int c, int n);
    if (n == 0) return 0;
    if (n == 1 && c == 1) return 2;
    return 3;
  endfunction

  function automatic int adv(int c, int p);
    return (c == 1) ? (p ^ 1) : 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // op: 0 ready, 1 token, 2 ack, 3 timeout, 4 flush, 5 toggle-init, 6 stalled token
  task automatic run_op(int op);
    int e_code[2], e_slot[2], e_irq[2];
    int was_full[2], was_cnt[2];
    string stag;
    @(negedge clk);
    case (op)
      0: pkt_ready = 1;
      1: tok = 1;
      2: ack = 1;
      3: tmo = 1;
      4: flush = 1;
      5: tinit = 1;
      default: begin stall = 1; tok = 1; end
    endcase
    for (int c = 0; c < 2; c++) begin
      e_code[c] = 0; e_slot[c] = -1; e_irq[c] = 0;
      was_cnt[c] = m_cnt[c];
      was_full[c] = (m_cnt[c] == c + 1);
      case (op)
        0: if (m_cnt[c] < c + 1) begin m_cnt[c]++; m_wr[c] = adv(c, m_wr[c]); end
        1: begin
          if (rfb || m_cnt[c] > 0) begin
            e_code[c] = m_tog[c] ? 2 : 1;
            e_slot[c] = (m_cnt[c] > 0) ? m_rd[c] : m_last[c];
            m_aw[c] = 1;
          end else begin
            e_code[c] = 3; m_aw[c] = 0;
          end
        end
        2: begin
          if (m_aw[c]) begin
            e_irq[c] = 1; m_tog[c] ^= 1;
            if (m_cnt[c] > 0) begin
              m_last[c] = m_rd[c]; m_rd[c] = adv(c, m_rd[c]); m_cnt[c]--;
            end
          end
          m_aw[c] = 0;
        end
        3: begin
          if (m_aw[c] && af) begin m_cnt[c] = 0; m_rd[c] = m_wr[c]; end
          m_aw[c] = 0;
        end
        4: begin m_cnt[c] = 0; m_rd[c] = m_wr[c]; m_aw[c] = 0; end
        5: if (m_cnt[c] == 0) begin
             m_rd[c] = 0; m_wr[c] = 0; m_last[c] = 0; m_tog[c] = 0; m_aw[c] = 0;
           end
        default: begin e_code[c] = 4; m_aw[c] = 0; end
      endcase
    end
    @(negedge clk);
    pkt_ready = 0; tok = 0; ack = 0; tmo = 0; flush = 0; tinit = 0; stall = 0;
    for (int c = 0; c < 2; c++) begin
      case (op)
        0: stag = was_full[c] ? "R10" : (c ? "R8" : "R7");
        2: stag = "R4";
        3: stag = af ? "R11" : "R6";
        4: stag = "R11";
        5: stag = (was_cnt[c] == 0) ? "R12" : "R9";
        default: stag = "R9";
      endcase
      chk(stag, "buf_sts", int'(st[c]), enc(c, m_cnt[c]));
      chk("R10", "wr_slot", int'(ws[c]), m_wr[c]);
      chk("R4", "ep_irq", int'(irq[c]), e_irq[c]);
      chk("R13", "rsp_valid", int'(rv[c]), (op == 1 || op == 6) ? 1 : 0);
      chk(op == 6 ? "R1" : (rfb ? "R3" : "R2"), "rsp_code", int'(rc[c]), e_code[c]);
      if (e_slot[c] >= 0)
        chk(was_cnt[c] == 0 ? "R5" : "R6", "rsp_slot", int'(rs[c]), e_slot[c]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_tog[c] = 0; m_rd[c] = 0; m_wr[c] = 0; m_last[c] = 0; m_aw[c] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R7", "reset buf_sts", int'(st[c]), 0);
      chk("R13", "reset rsp_valid", int'(rv[c]), 0);
      chk("R4", "reset ep_irq", int'(irq[c]), 0);
    end
    // Directed: empty token in each mode, then fill past capacity
    run_op(1);            // R2 NAK
    run_op(2);            // ignored ack
    rfb = 1; run_op(1);   // R3 DATA0 from last slot
    run_op(2);            // R4 toggle flips, no status change
    rfb = 0;
    run_op(0); run_op(0); run_op(0); // R10 overflow ignored
    run_op(1); run_op(3); run_op(1); // R6 retry same code
    run_op(5);            // R12 ignored when loaded
    run_op(4); run_op(5); // R11 then R12
    run_op(6);            // R1
    // Sweep in both modes, with auto-flush toggled
    for (int ph = 0; ph < 4; ph++) begin
      rfb = ph[0];
      af  = ph[1];
      for (int i = 0; i < 400; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        run_op(int'(lfsr[7:0]) % 7);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule